// File: doc/BRIEF.md
# Three-Phase Bridge Gate Guard

This block sits between six active-high PWM commands for a three-phase bridge and the six gate-enable lines that drive it. There are three upper (high-side) commands and three lower (low-side) commands. It also takes a short-circuit comparator flag, a low-side supply under-voltage flag and three per-phase high-side supply under-voltage flags. Every input is asynchronous. Each one passes through a synchroniser before the logic uses it.

A short circuit or a low-side under-voltage removes all three low-side gates at once. It also pulls the active-low fault line. A short circuit holds the fault line for a fixed minimum width, set in clock cycles by `FAULT_MIN_CYC`. The default of 2000 cycles is 20 µs at 100 MHz. An under-voltage holds the fault line for the whole under-voltage period, and never for less than that minimum. A high-side under-voltage removes only the gate of its own phase and leaves the fault line alone.

After any blanking, a gate comes back only on a fresh low-to-high edge of its command. The same rule applies after reset. A command that stays high through a fault therefore never re-enables its gate.

Top module: `inv_gate_guard`

## Requirements
- R1: Asserting `sc_flag_in` clears all three `gate_lo` bits, whatever `pwm_lo_in` holds. The bits clear `SYNC_STAGES`+1 clock cycles after the flag changes, which is 3 cycles at the default, and `gate_hi` is unaffected.
- R2: A short-circuit pulse shorter than `FAULT_MIN_CYC` drives `fault_n` low for exactly `FAULT_MIN_CYC` cycles. `fault_n` falls in the same cycle that the low gates clear, and `fault_kind` reads 0 (short circuit).
- R3: While `fault_n` is 0, every `gate_lo` bit stays 0, even when its command toggles low and then high.
- R4: When `fault_n` returns to 1, a low-side command that is still held high keeps its gate at 0. The gate turns on only after the command goes low and then high again.
- R5: A low-side under-voltage of W cycles, with W at least `FAULT_MIN_CYC`, clears all `gate_lo` bits. It also holds `fault_n` low for exactly W cycles, and `fault_kind` reads 1 (under-voltage).
- R6: A low-side under-voltage shorter than `FAULT_MIN_CYC` still holds `fault_n` low for exactly `FAULT_MIN_CYC` cycles.
- R7: `uv_hi_in[p]` clears only `gate_hi[p]`, after 3 cycles. `fault_n` stays 1 and the other gates are unchanged.
- R8: When `uv_hi_in[p]` clears, a `pwm_hi_in[p]` that is still high keeps `gate_hi[p]` at 0 until the command makes a new rising edge.
- R9: With no fault, a gate goes to 1 three cycles after its command rises from 0, and to 0 three cycles after the command falls. This holds for every combination of the six commands.
- R10: After reset, all gates are 0, `fault_n` is 1 and `fault_kind` is 0. A command held high through reset does not turn its gate on.
- R11: A short circuit and a low-side under-voltage that arrive in the same cycle report a short circuit first. If the under-voltage outlasts the short-circuit width, `fault_n` stays low without a break until the under-voltage ends, and `fault_kind` then reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_hi_in | input | PHASES | High-side commands, active high, bit p is phase p |
| pwm_lo_in | input | PHASES | Low-side commands, active high |
| sc_flag_in | input | 1 | Short-circuit comparator flag, active high |
| uv_lo_in | input | 1 | Low-side supply under-voltage flag, active high |
| uv_hi_in | input | PHASES | Per-phase high-side supply under-voltage flags |
| gate_hi | output | PHASES | High-side gate enables |
| gate_lo | output | PHASES | Low-side gate enables |
| fault_n | output | 1 | Fault line, 0 means fault asserted |
| fault_kind | output | 1 | Type of the latest low-side fault: 0 short circuit, 1 under-voltage |

## Verification
Two events can fall in the same cycle.

The first pair is a short circuit and a low-side under-voltage. The bench raises both flags on the same edge. It judges that `fault_kind` first reads short circuit, and that `fault_n` then stays low without a gap for the length of the under-voltage.

The second pair is a fault entry and the fresh command edge that would re-arm a gate. The bench toggles the low-side commands while the fault line is held. It then confirms that no gate escapes, either during the hold or after release while the command is still high.

// File: rtl/inv_guard_pkg.sv
package inv_guard_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SC   = 2'd1,
    ST_UV   = 2'd2
  } guard_st_t;

  localparam logic KIND_SC = 1'b0;
  localparam logic KIND_UV = 1'b1;
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) chain[s] <= chain[s-1];
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rearm_gate.sv
module rearm_gate (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic block,
  output logic gate
);
  logic prev_q;
  logic gate_q;
  logic rise;

  assign rise = din & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      gate_q <= 1'b0;
    end else begin
      prev_q <= din;
      if (block)
        gate_q <= 1'b0;
      else
        gate_q <= rise | (gate_q & din);
    end
  end

  assign gate = gate_q;
endmodule

// File: rtl/fault_seq.sv
module fault_seq
  import inv_guard_pkg::*;
#(
  parameter int MIN_CYC = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic sc,
  input  logic uv,
  output logic block_lo,
  output logic fault_n,
  output logic fault_kind
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(MIN_CYC - 1);

  guard_st_t      st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           kind_q, kind_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    unique case (st_q)
      ST_IDLE: begin
        if (sc) begin
          st_d = ST_SC; cnt_d = LOAD; kind_d = KIND_SC;
        end else if (uv) begin
          st_d = ST_UV; cnt_d = LOAD; kind_d = KIND_UV;
        end
      end
      ST_SC: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (sc) begin
          cnt_d = LOAD;
        end else if (uv) begin
          st_d = ST_UV; kind_d = KIND_UV;
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_UV: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (sc) begin
          st_d = ST_SC; cnt_d = LOAD; kind_d = KIND_SC;
        end else if (!uv) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      kind_q <= KIND_SC;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
    end
  end

  assign block_lo   = (st_q != ST_IDLE) | sc | uv;
  assign fault_n    = (st_q == ST_IDLE);
  assign fault_kind = kind_q;
endmodule

// File: rtl/inv_gate_guard.sv
module inv_gate_guard #(
  parameter int PHASES        = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int FAULT_MIN_CYC = 2000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PHASES-1:0] pwm_hi_in,
  input  logic [PHASES-1:0] pwm_lo_in,
  input  logic              sc_flag_in,
  input  logic              uv_lo_in,
  input  logic [PHASES-1:0] uv_hi_in,
  output logic [PHASES-1:0] gate_hi,
  output logic [PHASES-1:0] gate_lo,
  output logic              fault_n,
  output logic              fault_kind
);
  localparam int NSYNC = 3 * PHASES + 2;

  logic [NSYNC-1:0]  raw, syn;
  logic [PHASES-1:0] s_pwm_hi, s_pwm_lo, s_uv_hi;
  logic              s_sc, s_uv_lo, lo_block;

  assign raw = {uv_hi_in, uv_lo_in, sc_flag_in, pwm_lo_in, pwm_hi_in};

  sync_bank #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .d(raw), .q(syn)
  );

  assign s_pwm_hi = syn[PHASES-1:0];
  assign s_pwm_lo = syn[2*PHASES-1:PHASES];
  assign s_sc     = syn[2*PHASES];
  assign s_uv_lo  = syn[2*PHASES+1];
  assign s_uv_hi  = syn[3*PHASES+1:2*PHASES+2];

  fault_seq #(.MIN_CYC(FAULT_MIN_CYC)) u_seq (
    .clk(clk), .rst(rst), .sc(s_sc), .uv(s_uv_lo),
    .block_lo(lo_block), .fault_n(fault_n), .fault_kind(fault_kind)
  );

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    rearm_gate u_hi (
      .clk(clk), .rst(rst), .din(s_pwm_hi[p]), .block(s_uv_hi[p]),
      .gate(gate_hi[p])
    );
    rearm_gate u_lo (
      .clk(clk), .rst(rst), .din(s_pwm_lo[p]), .block(lo_block),
      .gate(gate_lo[p])
    );
  end
endmodule

// File: rtl/inv_gate_guard_chk.sv
module inv_gate_guard_chk #(
  parameter int PHASES        = 3,
  parameter int SYNC_STAGES   = 2,
  parameter int FAULT_MIN_CYC = 2000
) (
  input logic              clk,
  input logic              rst,
  input logic [PHASES-1:0] pwm_hi_in,
  input logic [PHASES-1:0] pwm_lo_in,
  input logic              sc_flag_in,
  input logic              uv_lo_in,
  input logic [PHASES-1:0] uv_hi_in,
  input logic [PHASES-1:0] gate_hi,
  input logic [PHASES-1:0] gate_lo,
  input logic              fault_n,
  input logic              fault_kind
);
  localparam int LAT = SYNC_STAGES + 1;

  logic [31:0] low_cnt;
  always_ff @(posedge clk) begin
    if (rst) low_cnt <= '0;
    else if (!fault_n) low_cnt <= low_cnt + 1'b1;
    else low_cnt <= '0;
  end

  // R3: no low gate while the fault line is held
  p_lo_off_in_fault_r3: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> gate_lo == '0);

  // R2 and R6: fault line never shorter than the minimum width
  p_min_width_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_n) |-> low_cnt >= FAULT_MIN_CYC);

  // R7: only the low-side flags can pull the fault line
  p_fault_source_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_n) |-> ($past(sc_flag_in, LAT) || $past(uv_lo_in, LAT)));

  // R1: short circuit blanks the low side
  p_sc_blank_r1: assert property (@(posedge clk) disable iff (rst)
    $past(sc_flag_in, LAT) |-> gate_lo == '0);

  // R11: kind tracks the reported fault while held
  p_kind_known_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_n) && $past(sc_flag_in, LAT) |-> fault_kind == 1'b0);

  for (genvar p = 0; p < PHASES; p++) begin : g_ch
    // R7: high-side under-voltage blanks its own gate
    p_hi_uv_blank_r7: assert property (@(posedge clk) disable iff (rst)
      $past(uv_hi_in[p], LAT) |-> !gate_hi[p]);
    // R4 and R8: gates turn on only after a fresh command edge
    p_lo_fresh_edge_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_lo[p]) |-> ($past(pwm_lo_in[p], LAT) && !$past(pwm_lo_in[p], LAT + 1)));
    p_hi_fresh_edge_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_hi[p]) |-> ($past(pwm_hi_in[p], LAT) && !$past(pwm_hi_in[p], LAT + 1)));
    // R9: a gate is on only while its command was high
    p_hi_follow_r9: assert property (@(posedge clk) disable iff (rst)
      gate_hi[p] |-> $past(pwm_hi_in[p], LAT));
    p_lo_follow_r9: assert property (@(posedge clk) disable iff (rst)
      gate_lo[p] |-> $past(pwm_lo_in[p], LAT));
  end
endmodule

bind inv_gate_guard inv_gate_guard_chk #(
  .PHASES(PHASES), .SYNC_STAGES(SYNC_STAGES), .FAULT_MIN_CYC(FAULT_MIN_CYC)
) u_chk (
  .clk(clk), .rst(rst), .pwm_hi_in(pwm_hi_in), .pwm_lo_in(pwm_lo_in),
  .sc_flag_in(sc_flag_in), .uv_lo_in(uv_lo_in), .uv_hi_in(uv_hi_in),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n),
  .fault_kind(fault_kind)
);

// File: tb/tb_inv_gate_guard.sv
`timescale 1ns/1ps
module tb_inv_gate_guard;
  localparam int P   = 3;
  localparam int MIN = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [P-1:0] pwm_hi_in = '0, pwm_lo_in = '0, uv_hi_in = '0;
  logic         sc_flag_in = 1'b0, uv_lo_in = 1'b0;
  logic [P-1:0] gate_hi, gate_lo;
  logic         fault_n, fault_kind;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  inv_gate_guard #(.PHASES(P), .SYNC_STAGES(2), .FAULT_MIN_CYC(MIN)) dut (
    .clk(clk), .rst(rst), .pwm_hi_in(pwm_hi_in), .pwm_lo_in(pwm_lo_in),
    .sc_flag_in(sc_flag_in), .uv_lo_in(uv_lo_in), .uv_hi_in(uv_hi_in),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n),
    .fault_kind(fault_kind)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure_low(output int c);
    c = 0;
    while (!fault_n && c < 1000) begin
      c++;
      step(1);
    end
  endtask

  // bring every command low, then high, so that all gates arm
  task automatic arm_all();
    pwm_hi_in = '0; pwm_lo_in = '0; step(4);
    pwm_hi_in = '1; pwm_lo_in = '1; step(4);
  endtask

  initial begin
    int c;
    pwm_lo_in = 3'b001;
    step(5);
    rst = 1'b0;
    step(6);
    // R10: reset state, held-high command does not turn on
    chk("R10 gate_lo", gate_lo, 0);
    chk("R10 gate_hi", gate_hi, 0);
    chk("R10 fault_n", fault_n, 1);
    chk("R10 fault_kind", fault_kind, 0);

    // R9: exhaustive over six commands
    for (int v = 0; v < 64; v++) begin
      pwm_hi_in = '0; pwm_lo_in = '0; step(4);
      pwm_hi_in = v[2:0]; pwm_lo_in = v[5:3];
      step(2);
      if (v == 63) chk("R9 not before latency", gate_lo, 0);
      step(1);
      chk("R9 hi follows", gate_hi, v & 7);
      chk("R9 lo follows", gate_lo, (v >> 3) & 7);
    end
    pwm_hi_in = '0; pwm_lo_in = '1; step(3);
    chk("R9 fall hi", gate_hi, 0);

    // R1 R2 R3 R4: short circuit
    arm_all();
    chk("R1 armed", gate_lo, 7);
    sc_flag_in = 1'b1; step(2); sc_flag_in = 1'b0; step(1);
    chk("R1 lo off", gate_lo, 0);
    chk("R1 hi kept", gate_hi, 7);
    chk("R2 fault_n low", fault_n, 0);
    chk("R2 kind sc", fault_kind, 0);
    c = 0;
    while (!fault_n && c < 1000) begin
      if (c == 4) pwm_lo_in = '0;
      if (c == 8) pwm_lo_in = '1;
      if (gate_lo != 0) chk("R3 lo off in fault", gate_lo, 0);
      c++;
      step(1);
    end
    chk("R3 checked", gate_lo, 0);
    chk("R2 width", c, MIN);
    step(5);
    chk("R4 held high stays off", gate_lo, 0);
    pwm_lo_in = '0; step(3); pwm_lo_in = '1; step(3);
    chk("R4 fresh edge on", gate_lo, 7);

    // R5: long low-side under-voltage
    arm_all();
    fork
      begin uv_lo_in = 1'b1; step(40); uv_lo_in = 1'b0; end
      begin step(3); chk("R5 lo off", gate_lo, 0); chk("R5 kind uv", fault_kind, 1);
            measure_low(c); chk("R5 width", c, 40); end
    join
    step(4);
    chk("R5 stays off after", gate_lo, 0);

    // R6: short under-voltage
    arm_all();
    fork
      begin uv_lo_in = 1'b1; step(5); uv_lo_in = 1'b0; end
      begin step(3); chk("R6 lo off", gate_lo, 0); measure_low(c); chk("R6 width", c, MIN); end
    join

    // R11: both low-side faults in one cycle
    arm_all();
    fork
      begin sc_flag_in = 1'b1; uv_lo_in = 1'b1; step(2); sc_flag_in = 1'b0;
            step(48); uv_lo_in = 1'b0; end
      begin step(3); chk("R11 kind sc first", fault_kind, 0);
            measure_low(c); chk("R11 continuous width", c, 50);
            chk("R11 kind uv last", fault_kind, 1); end
    join

    // R7 R8: high-side under-voltage on phase 1
    arm_all();
    uv_hi_in = 3'b010; step(3);
    chk("R7 only phase1 off", gate_hi, 3'b101);
    chk("R7 lo kept", gate_lo, 7);
    for (int k = 0; k < 10; k++) begin
      if (!fault_n) chk("R7 no fault", fault_n, 1);
      step(1);
    end
    chk("R7 no fault", fault_n, 1);
    uv_hi_in = '0; step(5);
    chk("R8 held high stays off", gate_hi, 3'b101);
    pwm_hi_in = 3'b101; step(3); pwm_hi_in = 3'b111; step(3);
    chk("R8 fresh edge on", gate_hi, 7);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule